// File: doc/BRIEF.md
# High-Color Pixel Expander

This block sits between a pixel source and a video DAC. On every rising edge of the pixel clock it captures one 16-bit packed pixel word and a mode code. It unpacks the word into three 8-bit channels, red, green and blue, without any palette lookup. Two packed layouts are recognised: a 5-5-5 layout whose top bit is unused, and a 5-6-5 layout. Each narrow channel is placed in the upper bits of its 8-bit output, and the bits it lacks are filled with zeros.

The mode code and an active-low blanking input travel through the same three register stages as the pixel data. Each output colour therefore matches the word, mode and blanking state that were captured together. A code that selects neither layout produces black with the valid flag low. Blanking forces black but leaves the valid flag as the mode decides. A synchronous active-low reset clears every stage.

Top module: `hicolor_expander`

## Requirements
- R1: The word, mode code and blanking level present at rising clock edge n drive the outputs from just after edge n+2 until edge n+3, through three register stages. A different input on every cycle gives a different output on every cycle.
- R2: Mode code 4'b0011 selects 5-5-5. Red comes from word bits 14:10, green from bits 9:5 and blue from bits 4:0. Word bit 15 has no effect on any output.
- R3: In 5-5-5 mode, each 5-bit field appears on bits 7:3 of its output channel, and bits 2:0 of every channel are zero.
- R4: Mode code 4'b0101 selects 5-6-5. Red comes from word bits 15:11, green from bits 10:5 and blue from bits 4:0.
- R5: In 5-6-5 mode, red and blue carry their field on bits 7:3 with bits 2:0 zero. Green carries its field on bits 7:2 with bits 1:0 zero.
- R6: Any other mode code gives zero on all three channels and a low `dacValid`. `dacValid` is high exactly when the aligned mode code is 4'b0011 or 4'b0101.
- R7: When `blankN` is low at the capturing edge, the aligned output colour is zero. `dacValid` still follows the mode code.
- R8: While `rstN` is low at a clock edge, all stages clear. After that edge the outputs are zero with `dacValid` low. Words captured before or during reset never reach the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; all capture on the rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| modeSel | input | 4 | Packed-layout select code, captured with each word |
| pixWord | input | 16 | Packed pixel word |
| blankN | input | 1 | Blanking, active low, captured with each word |
| dacRed | output | 8 | Expanded red channel |
| dacGreen | output | 8 | Expanded green channel |
| dacBlue | output | 8 | Expanded blue channel |
| dacValid | output | 1 | High when the aligned mode code is a known layout |

## Verification
The hardest case to reach from the ports is a change of mode, blanking or reset on every single cycle. Only then does a misaligned control stage show up as wrong colour on a neighbouring pixel. The vector table therefore streams back-to-back words that alternate layouts, unknown codes and blanking. A long random run then changes all three inputs on each clock against a three-deep expected queue. A directed test asserts reset for one edge while a legal word is being captured, and checks that neither that word nor the words still in the stages emerge afterwards.

// File: rtl/hicolor_pkg.sv
package hicolor_pkg;
  localparam int WORD_W = 16;
  localparam int CH_W   = 8;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_RGB555 = 4'b0011;
  localparam logic [MODE_W-1:0] MODE_RGB565 = 4'b0101;

  // Strobes handed from control to datapath, one set per pipeline stage
  typedef struct packed {
    logic legal;   // mode code names a known layout
    logic is565;   // layout is 5-6-5 (else 5-5-5)
    logic show;    // not blanked
  } strobe_t;
endpackage

// File: rtl/hicolor_ctrl.sv
module hicolor_ctrl
  import hicolor_pkg::*;
#(
  parameter int MODE_BITS = MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic                 blankN,
  output strobe_t              s1Strobe,
  output strobe_t              s2Strobe,
  output logic                 validOut
);
  localparam int STAGES = 3;

  strobe_t decoded;
  strobe_t stage [STAGES];

  always_comb begin
    decoded.legal = (modeSel == MODE_RGB555) || (modeSel == MODE_RGB565);
    decoded.is565 = (modeSel == MODE_RGB565);
    decoded.show  = blankN;
  end

  generate
    for (genvar st = 0; st < STAGES; st++) begin : g_stage
      if (st == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[st] <= '0;
          else       stage[st] <= decoded;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rstN) stage[st] <= '0;
          else       stage[st] <= stage[st-1];
        end
      end
    end
  endgenerate

  assign s1Strobe = stage[0];
  assign s2Strobe = stage[1];
  assign validOut = stage[STAGES-1].legal;

  AST_RESET_CLEARS_CTRL: assert property (@(posedge clk)
    !rstN |=> (!validOut && !s1Strobe.legal && !s2Strobe.legal)); // R8
endmodule

// File: rtl/hicolor_path.sv
module hicolor_path
  import hicolor_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int CH_BITS   = CH_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [WORD_BITS-1:0] pixWord,
  input  strobe_t              s1Strobe,
  input  strobe_t              s2Strobe,
  output logic [CH_BITS-1:0]   chanOut [3]
);
  localparam int PAD5 = CH_BITS - 5;
  localparam int PAD6 = CH_BITS - 6;

  logic [WORD_BITS-1:0] wordQ1;
  logic [CH_BITS-1:0]   exp555 [3];
  logic [CH_BITS-1:0]   exp565 [3];
  logic [CH_BITS-1:0]   chanQ2 [3];
  logic [CH_BITS-1:0]   chanQ3 [3];

  always_ff @(posedge clk) begin
    if (!rstN) wordQ1 <= '0;
    else       wordQ1 <= pixWord;
  end

  // Channel index 0 = blue, 1 = green, 2 = red
  generate
    for (genvar ch = 0; ch < 3; ch++) begin : g_chan
      localparam int LO555 = ch * 5;
      localparam int W565  = (ch == 1) ? 6 : 5;
      localparam int LO565 = (ch == 0) ? 0 : ((ch == 1) ? 5 : 11);

      assign exp555[ch] = {wordQ1[LO555 +: 5], {PAD5{1'b0}}};
      assign exp565[ch] = {wordQ1[LO565 +: W565], {(CH_BITS - W565){1'b0}}};

      always_ff @(posedge clk) begin
        if (!rstN)               chanQ2[ch] <= '0;
        else if (s1Strobe.is565) chanQ2[ch] <= exp565[ch];
        else                     chanQ2[ch] <= exp555[ch];
      end

      always_ff @(posedge clk) begin
        if (!rstN)                                chanQ3[ch] <= '0;
        else if (s2Strobe.legal && s2Strobe.show) chanQ3[ch] <= chanQ2[ch];
        else                                      chanQ3[ch] <= '0;
      end

      assign chanOut[ch] = chanQ3[ch];
    end
  endgenerate

  AST_RB_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (chanQ3[0][PAD5-1:0] == '0) && (chanQ3[2][PAD5-1:0] == '0)); // R3

  AST_GREEN_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    chanQ3[1][PAD6-1:0] == '0); // R5
endmodule

// File: rtl/hicolor_expander.sv
module hicolor_expander
  import hicolor_pkg::*;
#(
  parameter int WORD_BITS = WORD_W,
  parameter int CH_BITS   = CH_W,
  parameter int MODE_BITS = MODE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [MODE_BITS-1:0] modeSel,
  input  logic [WORD_BITS-1:0] pixWord,
  input  logic                 blankN,
  output logic [CH_BITS-1:0]   dacRed,
  output logic [CH_BITS-1:0]   dacGreen,
  output logic [CH_BITS-1:0]   dacBlue,
  output logic                 dacValid
);
  strobe_t            s1Strobe;
  strobe_t            s2Strobe;
  logic [CH_BITS-1:0] chanOut [3];

  hicolor_ctrl #(.MODE_BITS(MODE_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .modeSel  (modeSel),
    .blankN   (blankN),
    .s1Strobe (s1Strobe),
    .s2Strobe (s2Strobe),
    .validOut (dacValid)
  );

  hicolor_path #(.WORD_BITS(WORD_BITS), .CH_BITS(CH_BITS)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .pixWord  (pixWord),
    .s1Strobe (s1Strobe),
    .s2Strobe (s2Strobe),
    .chanOut  (chanOut)
  );

  assign dacBlue  = chanOut[0];
  assign dacGreen = chanOut[1];
  assign dacRed   = chanOut[2];

  // Checking aid: counts clean edges since reset so that $past stays inside them
  logic [1:0] fillCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                fillCnt <= '0;
    else if (fillCnt != 2'd3) fillCnt <= fillCnt + 2'd1;
  end

  AST_VALID_FOLLOWS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (fillCnt == 2'd3) |-> (dacValid == (($past(modeSel, 3) == MODE_RGB555) ||
                                        ($past(modeSel, 3) == MODE_RGB565)))); // R6

  AST_IDLE_IS_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    !dacValid |-> (dacRed == '0 && dacGreen == '0 && dacBlue == '0)); // R6

  AST_BLANK_IS_BLACK: assert property (@(posedge clk) disable iff (!rstN)
    ((fillCnt == 2'd3) && !$past(blankN, 3)) |->
      (dacRed == '0 && dacGreen == '0 && dacBlue == '0)); // R7

  AST_RED565_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    ((fillCnt == 2'd3) && ($past(modeSel, 3) == MODE_RGB565) && $past(blankN, 3)) |->
      (dacRed[CH_BITS-1 -: 5] == $past(pixWord[WORD_BITS-1 -: 5], 3))); // R1

  AST_GREEN555_PAD: assert property (@(posedge clk) disable iff (!rstN)
    ((fillCnt == 2'd3) && ($past(modeSel, 3) == MODE_RGB555)) |->
      (dacGreen[CH_BITS-6 : 0] == '0)); // R3

  AST_RESET_BLACK: assert property (@(posedge clk)
    !rstN |=> (dacRed == '0 && dacGreen == '0 && dacBlue == '0 && !dacValid)); // R8
endmodule

// File: tb/hicolor_expander_bench.sv
module hicolor_expander_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modeSel = 4'h0;
  logic [15:0] pixWord = 16'h0;
  logic       blankN = 1'b1;
  logic [7:0] dacRed, dacGreen, dacBlue;
  logic       dacValid;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  hicolor_expander u_hicolor_expander (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .pixWord(pixWord),
    .blankN(blankN), .dacRed(dacRed), .dacGreen(dacGreen),
    .dacBlue(dacBlue), .dacValid(dacValid)
  );

  // fields: mode[45:42] word[41:26] blankN[25] rgb[24:1] valid[0]
  localparam int NVEC = 16;
  localparam logic [45:0] VEC [NVEC] = '{
    {4'h3, 16'h7FFF, 1'b1, 24'hF8F8F8, 1'b1},  // R2 R3 all fields
    {4'h3, 16'h8000, 1'b1, 24'h000000, 1'b1},  // R2 bit 15 ignored
    {4'h3, 16'h7C00, 1'b1, 24'hF80000, 1'b1},  // R2 red field
    {4'h3, 16'h03E0, 1'b1, 24'h00F800, 1'b1},  // R2 green field
    {4'h3, 16'h001F, 1'b1, 24'h0000F8, 1'b1},  // R2 blue field
    {4'h5, 16'hFFFF, 1'b1, 24'hF8FCF8, 1'b1},  // R4 R5
    {4'h5, 16'hF800, 1'b1, 24'hF80000, 1'b1},  // R4 red
    {4'h5, 16'h07E0, 1'b1, 24'h00FC00, 1'b1},  // R4 green
    {4'h5, 16'h0020, 1'b1, 24'h000400, 1'b1},  // R5 green lsb on bit 2
    {4'h5, 16'h001F, 1'b1, 24'h0000F8, 1'b1},  // R4 blue
    {4'h3, 16'h0421, 1'b1, 24'h080808, 1'b1},  // R3 field lsbs
    {4'h5, 16'h0841, 1'b1, 24'h080808, 1'b1},  // R5 field lsbs
    {4'h0, 16'hFFFF, 1'b1, 24'h000000, 1'b0},  // R6
    {4'h7, 16'hFFFF, 1'b1, 24'h000000, 1'b0},  // R6
    {4'h5, 16'hFFFF, 1'b0, 24'h000000, 1'b1},  // R7
    {4'h3, 16'h7FFF, 1'b0, 24'h000000, 1'b1}   // R7
  };

  function automatic logic [24:0] model(logic [3:0] m, logic [15:0] w, logic b);
    logic [23:0] rgb;
    logic        v;
    case (m)
      4'b0011: begin rgb = {w[14:10], 3'b0, w[9:5], 3'b0, w[4:0], 3'b0}; v = 1'b1; end
      4'b0101: begin rgb = {w[15:11], 3'b0, w[10:5], 2'b0, w[4:0], 3'b0}; v = 1'b1; end
      default: begin rgb = 24'h0; v = 1'b0; end
    endcase
    if (!b) rgb = 24'h0;
    return {rgb, v};
  endfunction

  task automatic check(string req, logic [24:0] expv);
    logic [24:0] act;
    act = {dacRed, dacGreen, dacBlue, dacValid};
    checkCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s: got rgb=%h valid=%b, expected rgb=%h valid=%b",
               req, act[24:1], act[0], expv[24:1], expv[0]);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got hang, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [24:0] expQ [$];
    // Reset state, R8
    modeSel = 4'h3; pixWord = 16'h7FFF;
    repeat (3) @(negedge clk);
    check("R8 reset state", 25'h0);
    rstN = 1'b1;
    modeSel = 4'h0;
    repeat (3) @(negedge clk);
    check("R8 idle after reset", 25'h0);

    // Table walk, R1..R7, back to back
    for (int i = 0; i < NVEC + 3; i++) begin
      if (i >= 3) check("R1 vector stream", VEC[i-3][24:0]);
      if (i < NVEC) begin
        modeSel = VEC[i][45:42]; pixWord = VEC[i][41:26]; blankN = VEC[i][25];
      end else begin
        modeSel = 4'h0; pixWord = 16'h0; blankN = 1'b1;
      end
      @(negedge clk);
    end

    // Random stream with three-deep expected queue, R1 R2 R4 R6 R7
    for (int i = 0; i < 403; i++) begin
      if (i >= 3) check("R1 random stream", expQ.pop_front());
      begin
        int r;
        r = $urandom % 8;
        modeSel = (r < 3) ? 4'h3 : ((r < 6) ? 4'h5 : 4'($urandom));
      end
      pixWord = 16'($urandom);
      blankN  = ($urandom % 6) != 0;
      expQ.push_back(model(modeSel, pixWord, blankN));
      @(negedge clk);
    end

    // Reset in mid-stream, R8: legal words in flight are discarded
    modeSel = 4'h5; pixWord = 16'hFFFF; blankN = 1'b1;
    repeat (2) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 cleared by reset edge", 25'h0);
    rstN = 1'b1;
    modeSel = 4'h0;
    @(negedge clk);
    check("R8 stage 2 cleared", 25'h0);
    @(negedge clk);
    check("R8 stage 3 cleared", 25'h0);
    @(negedge clk);
    check("R8 reset-edge word dropped", 25'h0);

    // Single legal word after idle, R1 exact cycle
    modeSel = 4'h3; pixWord = 16'h7FFF;
    @(negedge clk);
    modeSel = 4'h0; pixWord = 16'h0;
    @(negedge clk);
    check("R1 not early", 25'h0);
    @(negedge clk);
    check("R1 arrives on third edge", {24'hF8F8F8, 1'b1});
    @(negedge clk);
    check("R1 lasts one cycle", 25'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule